// File: doc/BRIEF.md
# Decimal Mantissa Shifter and Normalizer

This block holds a twelve-digit packed BCD mantissa (four bits per digit, 48 bits in all) and moves it by whole digits on command. The most significant digit sits in bits 47:44. Four operations are offered: a one-digit right shift, a one-digit left shift, a right shift by a count of digits, and a normalize. A one-digit shift brings a caller-supplied digit in at the vacated end and hands back the digit pushed out. Normalize moves the value left until its leading digit is nonzero, reports how many places it moved, and raises a flag when the whole mantissa was zero.

A floating-point decimal datapath uses it between arithmetic steps. It aligns operands before an add, drops guard digits after one, and left-justifies results. The caller loads a value, issues a command with a single-cycle start pulse, and waits for the one-cycle done pulse. It then reads the mantissa, the spilled digit, the shift count and the flag. The block performs one digit move per clock while busy. Digit addition and instruction decoding are left to neighbouring logic.

Top module: `dms_shift_norm`

## Requirements
- R1: A synchronous active-low reset clears the mantissa, the spilled digit, the shift count, the flag, busy and done.
- R2: While idle, `load` writes `load_val` into the mantissa at the next edge. A load while busy is ignored. When `load` and `start` are high together, the load is taken and the start is dropped.
- R3: Op code 0 (one-digit right shift) puts `digit_in` into bits 47:44, moves every other digit down one place, returns the old bits 3:0 on `digit_out`, and leaves the flag low.
- R4: Op code 1 (one-digit left shift) puts `digit_in` into bits 3:0, moves every other digit up one place, discards what passes bit 47, returns the old bits 47:44 on `digit_out`, and leaves the flag low.
- R5: Op code 2 (counted right shift) shifts right N times, where N is `count_in` (0 to 15). The first shift brings in `digit_in` and every later shift brings in zero. `digit_out` ends as the last digit shifted out. With N = 0 the mantissa is unchanged and `digit_out` equals `digit_in`. The flag ends low.
- R6: Op code 3 (normalize) shifts left with zero fill while the top digit is zero and reports the number of shifts on `shift_cnt`. For a nonzero mantissa the flag ends low.
- R7: Normalize of an all-zero mantissa ends with `shift_cnt` = 12, the flag high and the mantissa still zero.
- R8: Exactly one digit moves per clock while busy. `done` is high for one cycle, in the cycle after the last busy cycle, with busy low. Counting clocks from the start edge to the first cycle with done seen: 2 for op 0 and op 1; max(N,1)+1 for op 2; k+2 for a normalize that makes k < 12 shifts; 14 for an all-zero normalize.
- R9: A `start` pulse while busy is ignored and does not change the operation in progress.
- R10: `shift_cnt` is written only by normalize and `digit_out` only by ops 0, 1 and 2. The flag is low while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command strobe, taken only when idle |
| op | input | 2 | Operation code: 0 right one, 1 left one, 2 right by count, 3 normalize |
| load | input | 1 | Write `load_val` into the mantissa when idle |
| load_val | input | 48 | Mantissa value to load |
| digit_in | input | 4 | Digit shifted in by ops 0, 1 and 2 |
| count_in | input | 4 | Digit count for op 2 |
| mant | output | 48 | Stored mantissa |
| digit_out | output | 4 | Last digit shifted out |
| shift_cnt | output | 4 | Number of normalize shifts |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dcarry | output | 1 | Decimal-carry flag, set by an all-zero normalize |

## Verification
The one-digit shifts are swept over every fill digit against several mantissas with distinct digits in every position, so a misrouted digit or a swapped direction shows in the result or the spill. The counted shift runs every count from 0 to 15. This separates the zero-count case, the first-fill-then-zero rule and counts past twelve, where the fill digit itself is spilled and then only zeros come out. Normalize runs every number of leading zeros from none to twelve, which tells an early or late stop from a correct one through both the count and the latency. A start during busy, a load during busy and a load together with a start confirm that the block ignores them.

// File: rtl/dms_pkg.sv
// Package: shared operation codes for the decimal mantissa shifter.
// Assumes a 2-bit op field; the code values are part of the port contract.
package dms_pkg;
    typedef enum logic [1:0] {
        OP_RIGHT1 = 2'd0,
        OP_LEFT1  = 2'd1,
        OP_RIGHTN = 2'd2,
        OP_NORM   = 2'd3
    } dms_op_e;
endpackage

// File: rtl/dms_digit_shift.sv
// Module: one-digit shifter of a packed digit vector, either direction.
// Purely combinational. Assumes DIGITS >= 2. The fill digit enters at the
// vacated end and the digit leaving the other end appears on spill.
module dms_digit_shift #(
    parameter int DIGITS = 12,
    parameter int DW     = 4,
    localparam int MW    = DIGITS * DW
) (
    input  logic [MW-1:0] val,
    input  logic [DW-1:0] fill,
    input  logic          dir_left,
    output logic [MW-1:0] res,
    output logic [DW-1:0] spill
);
    // Per-digit source selection; the end digits take the fill.
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [DW-1:0] from_lo;
        logic [DW-1:0] from_hi;
        if (g == 0) begin : g_lo_end
            assign from_lo = fill;
        end else begin : g_lo_mid
            assign from_lo = val[(g-1)*DW +: DW];
        end
        if (g == DIGITS - 1) begin : g_hi_end
            assign from_hi = fill;
        end else begin : g_hi_mid
            assign from_hi = val[(g+1)*DW +: DW];
        end
        assign res[g*DW +: DW] = dir_left ? from_lo : from_hi;
    end

    // The digit leaving the vector.
    assign spill = dir_left ? val[MW-1 -: DW] : val[DW-1:0];
endmodule

// File: rtl/dms_lead_detect.sv
// Module: flags a zero leading digit of the packed mantissa.
// Combinational; assumes the leading digit occupies the top DW bits.
module dms_lead_detect #(
    parameter int DIGITS = 12,
    parameter int DW     = 4,
    localparam int MW    = DIGITS * DW
) (
    input  logic [MW-1:0] val,
    output logic          top_zero
);
    // Leading-digit zero test.
    assign top_zero = (val[MW-1 -: DW] == '0);
endmodule

// File: rtl/dms_ctrl.sv
// Module: command sequencer for the mantissa shifter.
// Accepts a command when idle, then issues one digit shift per busy cycle
// until the operation's end condition. Holds the fill digit, the remaining
// count for the counted shift and the normalize shift count. Assumes the
// datapath applies do_shift in the same cycle. Reset is synchronous, active low.
module dms_ctrl
    import dms_pkg::*;
#(
    parameter int DIGITS = 12,
    parameter int DW     = 4,
    parameter int CNTW   = 4,
    localparam int RW    = $clog2(DIGITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  dms_op_e       op,
    input  logic [DW-1:0] digit_in,
    input  logic [CNTW-1:0] count_in,
    input  logic          top_zero,
    output logic          busy,
    output logic          done,
    output logic          do_shift,
    output logic          dir_left,
    output logic [DW-1:0] fill,
    output logic          finish,
    output logic          zero_hit,
    output logic          spill_en,
    output logic [RW-1:0] norm_cnt
);
    dms_op_e         op_q;
    logic [DW-1:0]   fill_q;
    logic [CNTW-1:0] rem_q;
    logic            last_rem;
    logic            norm_stop;

    assign last_rem  = (rem_q == '0) || (rem_q == CNTW'(1));
    assign norm_stop = !top_zero || (norm_cnt == RW'(DIGITS));

    // Per-cycle decision: whether to shift, in which direction, and whether to stop.
    always_comb begin
        do_shift = 1'b0;
        finish   = 1'b0;
        dir_left = 1'b0;
        fill     = fill_q;
        zero_hit = 1'b0;
        spill_en = 1'b0;
        if (busy) begin
            unique case (op_q)
                OP_RIGHT1: begin
                    do_shift = 1'b1;
                    finish   = 1'b1;
                    spill_en = 1'b1;
                end
                OP_LEFT1: begin
                    do_shift = 1'b1;
                    finish   = 1'b1;
                    dir_left = 1'b1;
                    spill_en = 1'b1;
                end
                OP_RIGHTN: begin
                    do_shift = (rem_q != '0);
                    spill_en = (rem_q != '0);
                    finish   = last_rem;
                end
                OP_NORM: begin
                    dir_left = 1'b1;
                    fill     = '0;
                    do_shift = !norm_stop;
                    finish   = norm_stop;
                    zero_hit = norm_stop && (norm_cnt == RW'(DIGITS));
                end
                default: ;
            endcase
        end
    end

    // Busy and done sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (accept)      busy <= 1'b1;
            else if (finish) busy <= 1'b0;
        end
    end

    // Command capture and per-shift updates of fill and remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_RIGHT1;
            fill_q <= '0;
            rem_q  <= '0;
        end else if (accept) begin
            op_q   <= op;
            fill_q <= digit_in;
            rem_q  <= count_in;
        end else if (do_shift && op_q == OP_RIGHTN) begin
            fill_q <= '0;
            rem_q  <= rem_q - CNTW'(1);
        end
    end

    // Normalize shift counter, cleared when a normalize is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            norm_cnt <= '0;
        end else if (accept && op == OP_NORM) begin
            norm_cnt <= '0;
        end else if (do_shift && op_q == OP_NORM) begin
            norm_cnt <= norm_cnt + RW'(1);
        end
    end
endmodule

// File: rtl/dms_shift_norm.sv
// Module: top of the decimal mantissa shifter and normalizer.
// Holds the packed BCD mantissa, the spilled digit and the decimal-carry
// flag; the sequencer in dms_ctrl steps one digit per busy cycle. Assumes
// the caller waits for done before reading results. Reset is synchronous,
// active low.
module dms_shift_norm
    import dms_pkg::*;
#(
    parameter int DIGITS = 12,
    parameter int DW     = 4,
    parameter int CNTW   = 4,
    localparam int MW    = DIGITS * DW,
    localparam int RW    = $clog2(DIGITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic            load,
    input  logic [MW-1:0]   load_val,
    input  logic [DW-1:0]   digit_in,
    input  logic [CNTW-1:0] count_in,
    output logic [MW-1:0]   mant,
    output logic [DW-1:0]   digit_out,
    output logic [RW-1:0]   shift_cnt,
    output logic            busy,
    output logic            done,
    output logic            dcarry
);
    logic            accept;
    logic            do_shift;
    logic            dir_left;
    logic [DW-1:0]   fill;
    logic            finish;
    logic            zero_hit;
    logic            spill_en;
    logic            top_zero;
    logic [MW-1:0]   shifted;
    logic [DW-1:0]   spill;
    dms_op_e         op_in;

    assign op_in  = dms_op_e'(op);
    assign accept = start && !busy && !load;

    dms_ctrl #(.DIGITS(DIGITS), .DW(DW), .CNTW(CNTW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .op       (op_in),
        .digit_in (digit_in),
        .count_in (count_in),
        .top_zero (top_zero),
        .busy     (busy),
        .done     (done),
        .do_shift (do_shift),
        .dir_left (dir_left),
        .fill     (fill),
        .finish   (finish),
        .zero_hit (zero_hit),
        .spill_en (spill_en),
        .norm_cnt (shift_cnt)
    );

    dms_digit_shift #(.DIGITS(DIGITS), .DW(DW)) u_shift (
        .val      (mant),
        .fill     (fill),
        .dir_left (dir_left),
        .res      (shifted),
        .spill    (spill)
    );

    dms_lead_detect #(.DIGITS(DIGITS), .DW(DW)) u_lead (
        .val      (mant),
        .top_zero (top_zero)
    );

    // Mantissa register: load when idle, otherwise take each digit shift.
    always_ff @(posedge clk) begin
        if (!rst_n)               mant <= '0;
        else if (!busy && load)   mant <= load_val;
        else if (do_shift)        mant <= shifted;
    end

    // Spilled digit: preset to the fill for a counted shift, then each spill.
    always_ff @(posedge clk) begin
        if (!rst_n)                          digit_out <= '0;
        else if (accept && op_in == OP_RIGHTN) digit_out <= digit_in;
        else if (spill_en)                   digit_out <= spill;
    end

    // Decimal-carry flag: cleared on accept, set only by an all-zero normalize.
    always_ff @(posedge clk) begin
        if (!rst_n)      dcarry <= 1'b0;
        else if (accept) dcarry <= 1'b0;
        else if (finish) dcarry <= zero_hit;
    end
endmodule

// File: rtl/dms_shift_norm_chk.sv
// Module: assertion checker for dms_shift_norm, attached by bind.
// Observes ports only. Reset is synchronous, active low.
module dms_shift_norm_chk #(
    parameter int DIGITS = 12,
    parameter int RW     = 4,
    parameter int MW     = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          load,
    input logic [MW-1:0] mant,
    input logic [RW-1:0] shift_cnt,
    input logic          busy,
    input logic          done,
    input logic          dcarry
);
    // Done never overlaps busy.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // Done follows a busy cycle.
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // Busy only rises from an idle start.
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start) && !$past(load));

    // Idle with no load keeps the mantissa.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(mant));

    // Flag set only together with a full-length normalize count.
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dcarry |-> shift_cnt == RW'(DIGITS));

    // Flag low while an operation runs.
    assert_flag_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dcarry);
endmodule

bind dms_shift_norm dms_shift_norm_chk #(.DIGITS(DIGITS), .RW(RW), .MW(MW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load      (load),
    .mant      (mant),
    .shift_cnt (shift_cnt),
    .busy      (busy),
    .done      (done),
    .dcarry    (dcarry)
);

// File: tb/tb_dms_shift_norm.sv
`timescale 1ns/1ps
module tb_dms_shift_norm;
    localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        load = 1'b0;
    logic [47:0] load_val = '0;
    logic [3:0]  digit_in = '0;
    logic [3:0]  count_in = '0;
    logic [47:0] mant;
    logic [3:0]  digit_out;
    logic [3:0]  shift_cnt;
    logic        busy;
    logic        done;
    logic        dcarry;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dms_shift_norm dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .load(load),
        .load_val(load_val), .digit_in(digit_in), .count_in(count_in),
        .mant(mant), .digit_out(digit_out), .shift_cnt(shift_cnt),
        .busy(busy), .done(done), .dcarry(dcarry)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [47:0] v);
        @(negedge clk);
        load = 1'b1; load_val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Issue a command and count clocks until done is seen.
    task automatic run_op(input logic [1:0] o, input logic [3:0] d, input logic [3:0] c,
                          output int lat);
        @(negedge clk);
        start = 1'b1; op = o; digit_in = d; count_in = c;
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [47:0] pat(input int i);
        logic [63:0] v;
        v = 64'h0;
        for (int j = 0; j < 12; j++)
            v = v * 16 + 64'((j * 7 + i * 5 + 1) % 16);
        return v[47:0];
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int lat;
        logic [63:0] w, em, eo;
        logic [47:0] m, base;
        int k;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(mant == 0 && digit_out == 0 && shift_cnt == 0 && !busy && !done && !dcarry,
              "R1 reset", {mant, digit_out, shift_cnt}, 0);
        rst_n = 1'b1;

        // R2 load
        do_load(48'h123456789012);
        check(mant == 48'h123456789012, "R2 load", mant, 48'h123456789012);

        // R7 zero normalize sets flag, then R3 clears it
        do_load(48'h0);
        run_op(2'd3, 4'h0, 4'h0, lat);
        check(mant == 0, "R7 mantissa", mant, 0);
        check(shift_cnt == 4'd12, "R7 count", shift_cnt, 12);
        check(dcarry, "R7 flag", dcarry, 1);
        check(lat == 14, "R8 zero normalize latency", lat, 14);
        @(negedge clk);
        check(!done && !busy, "R8 done single pulse", done, 0);

        // R3 one-digit right, all fill digits
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 16; d++) begin
                m = pat(p);
                do_load(m);
                run_op(2'd0, 4'(d), 4'h0, lat);
                w = {12'h0, 4'(d), m};
                em = (w >> 4) & M48; eo = m[3:0];
                check(mant == em[47:0], "R3 mantissa", mant, em);
                check(digit_out == eo[3:0], "R3 spill", digit_out, eo);
                check(!dcarry, "R3 flag", dcarry, 0);
                check(lat == 2, "R8 right1 latency", lat, 2);
                check(shift_cnt == 4'd12, "R10 count kept", shift_cnt, 12);
            end
        end

        // R4 one-digit left, all fill digits
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 16; d++) begin
                m = pat(p + 7);
                do_load(m);
                run_op(2'd1, 4'(d), 4'h0, lat);
                em = ((64'(m) << 4) | 64'(d)) & M48; eo = 64'(m[47:44]);
                check(mant == em[47:0], "R4 mantissa", mant, em);
                check(digit_out == eo[3:0], "R4 spill", digit_out, eo);
                check(!dcarry && lat == 2, "R4 flag/latency", {dcarry, 8'(lat)}, 2);
            end
        end

        // R5 counted right shift, every count
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n < 16; n++) begin
                m = pat(p + 3);
                do_load(m);
                run_op(2'd2, 4'(9 - p), 4'(n), lat);
                w = {12'h0, 4'(9 - p), m};
                if (n == 0) begin
                    em = 64'(m); eo = 64'(9 - p);
                end else begin
                    em = (w >> (4 * n)) & M48;
                    eo = (w >> (4 * (n - 1))) & 64'hF;
                end
                check(mant == em[47:0], "R5 mantissa", mant, em);
                check(digit_out == eo[3:0], "R5 spill", digit_out, eo);
                check(!dcarry, "R5 flag", dcarry, 0);
                check(lat == ((n == 0) ? 2 : n + 1), "R8 counted latency", lat,
                      (n == 0) ? 2 : n + 1);
            end
        end

        // R6 normalize, every leading-zero count
        base = 48'h9A0305000071;
        for (int z = 0; z <= 12; z++) begin
            m = (z == 12) ? 48'h0 : (base >> (4 * z));
            do_load(m);
            // preset digit_out to a known value through a counted shift of zero
            run_op(2'd2, 4'h5, 4'h0, lat);
            k = 0;
            em = 64'(m);
            while (k < 12 && em[47:44] == 4'h0) begin
                em = (em << 4) & M48;
                k++;
            end
            run_op(2'd3, 4'hF, 4'h0, lat);
            check(shift_cnt == 4'(k), "R6 count", shift_cnt, k);
            check(mant == em[47:0], "R6 mantissa", mant, em);
            check(dcarry == (k == 12), "R6 flag", dcarry, (k == 12));
            check(lat == ((k == 12) ? 14 : k + 2), "R8 normalize latency", lat,
                  (k == 12) ? 14 : k + 2);
            check(digit_out == 4'h5, "R10 spill kept by normalize", digit_out, 5);
        end

        // R9 start and load while busy are ignored
        do_load(48'h0);
        @(negedge clk);
        start = 1'b1; op = 2'd3;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; op = 2'd0; digit_in = 4'h7;
        load = 1'b1; load_val = 48'hFFFF_FFFF_FFFF;
        @(negedge clk);
        start = 1'b0; load = 1'b0;
        lat = 3;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(mant == 0, "R9 mantissa untouched", mant, 0);
        check(shift_cnt == 4'd12 && dcarry, "R9 normalize finished", shift_cnt, 12);
        check(lat == 14, "R9 latency unchanged", lat, 14);
        @(negedge clk);
        check(!busy, "R9 no second operation", busy, 0);

        // R2 load beats start in the same cycle
        @(negedge clk);
        start = 1'b1; op = 2'd1; load = 1'b1; load_val = 48'h314159265358;
        @(negedge clk);
        start = 1'b0; load = 1'b0;
        check(!busy && mant == 48'h314159265358, "R2 load over start", mant,
              48'h314159265358);
        @(negedge clk);
        check(!busy && !done && mant == 48'h314159265358, "R2 start dropped", busy, 0);

        // R1 reset during an operation
        do_load(48'h0);
        @(negedge clk);
        start = 1'b1; op = 2'd3;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && !dcarry && shift_cnt == 0 && mant == 0 && digit_out == 0,
              "R1 reset mid-run", {busy, shift_cnt}, 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule